// File: doc/BRIEF.md
# 64-bit Integer Execution Unit

This block is the integer arithmetic unit of a 64-bit processor core that runs 32-bit instruction words. It is purely combinational. It receives the raw instruction word and the two source register values, called rs and rt. From these it decodes the operation, picks the second operand and forms the result in the same cycle. The operand is either rt or the 16-bit immediate, sign- or zero-extended depending on the operation. The operations are:

- add and subtract, each in a checked and an unchecked variant;
- the four bitwise logic functions;
- logical and arithmetic shifts across the full 64 bits;
- signed and unsigned set-less-than;
- load-upper-immediate.

Shifts take a six-bit amount. Immediate forms build it from instruction bit 21 (the high bit) and bits 10..6. Variable forms take it from the low six bits of rs. A checked add or subtract that overflows raises the overflow flag next to the wrapped result. Control logic outside the block decides whether to suppress the register write.

Top module: `alu64`

## Requirements
- R1: Add (opcode 0, funct 0x20/0x21) gives rs+rt. Subtract (funct 0x22/0x23) gives rs-rt. Immediate add (opcode 0x08/0x09) gives rs plus the extended immediate. All results wrap modulo 2^64. The opcode field is bits 31..26, funct is bits 5..0 and the immediate is bits 15..0.
- R2: ovf_o is set only by the checked forms: funct 0x20, funct 0x22 and opcode 0x08. It is set exactly when the operands, with the subtrahend negated, share a sign that differs from the sign of the result. Every other operation leaves ovf_o at 0.
- R3: Funct 0x24, 0x25, 0x26 and 0x27 give the bitwise AND, OR, XOR and NOR of rs and rt.
- R4: Funct 0x00, 0x02 and 0x03 shift rt left logically, right logically and right arithmetically. The amount is {instr[21], instr[10:6]}, with range 0..63. An amount of 0 returns rt unchanged.
- R5: Funct 0x04, 0x06 and 0x07 perform the same three shifts, but the amount is rs[5:0]. The upper bits of rs have no effect.
- R6: Arithmetic right shifts fill the vacated bits with rt[63]. Logical shifts fill them with zeros.
- R7: Set-less-than writes exactly 1 or 0. The forms are funct 0x2A (signed, rs<rt), funct 0x2B (unsigned), opcode 0x0A (signed, immediate) and opcode 0x0B (unsigned, immediate).
- R8: Opcodes 0x08 and 0x0A sign-extend the immediate. Opcodes 0x09, 0x0B, 0x0C (AND), 0x0D (OR) and 0x0E (XOR) zero-extend it.
- R9: Opcode 0x0F places the immediate in bits 31..16. All other result bits are 0, and rs is ignored.
- R10: Any other opcode or funct gives result 0 with ovf_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_i | input | 64 | First source register value |
| rt_i | input | 64 | Second source register value |
| result_o | output | 64 | Operation result |
| ovf_o | output | 1 | Signed overflow of a checked add or subtract |

## Verification
On every evaluation, the assertions check the following invariants:

- ovf_o rises only for checked add or subtract;
- an add that overflows flips the sign of rs;
- set-less-than yields a single bit;
- load-upper-immediate leaves its low half zero;
- unsupported encodings give zero;
- a zero shift amount returns rt untouched.

The actual arithmetic values need the bench's vectors. These cover:

- the split immediate shift field and shift amounts of 32 and above;
- fill bits on arithmetic shifts;
- the choice between sign and zero extension;
- the signed versus unsigned comparison of the same operands.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLL, OP_SRL, OP_SRA, OP_SLT, OP_SLTU, OP_LUI
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    chk;       // overflow-checked variant
    logic    use_imm;   // second operand from immediate
    logic    imm_sext;  // sign-extend the immediate
    logic    var_sh;    // shift amount from rs
  } alu_ctl_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [31:0] instr_i,
  output alu_ctl_t    ctl_o
);
  logic [5:0] opc, fn;
  assign opc = instr_i[31:26];
  assign fn  = instr_i[5:0];

  always_comb begin
    ctl_o = '{op: OP_NONE, chk: 1'b0, use_imm: 1'b0, imm_sext: 1'b0, var_sh: 1'b0};
    if (opc == 6'h00) begin
      unique case (fn)
        6'h20: begin ctl_o.op = OP_ADD; ctl_o.chk = 1'b1; end
        6'h21: ctl_o.op = OP_ADD;
        6'h22: begin ctl_o.op = OP_SUB; ctl_o.chk = 1'b1; end
        6'h23: ctl_o.op = OP_SUB;
        6'h24: ctl_o.op = OP_AND;
        6'h25: ctl_o.op = OP_OR;
        6'h26: ctl_o.op = OP_XOR;
        6'h27: ctl_o.op = OP_NOR;
        6'h00: ctl_o.op = OP_SLL;
        6'h02: ctl_o.op = OP_SRL;
        6'h03: ctl_o.op = OP_SRA;
        6'h04: begin ctl_o.op = OP_SLL; ctl_o.var_sh = 1'b1; end
        6'h06: begin ctl_o.op = OP_SRL; ctl_o.var_sh = 1'b1; end
        6'h07: begin ctl_o.op = OP_SRA; ctl_o.var_sh = 1'b1; end
        6'h2A: ctl_o.op = OP_SLT;
        6'h2B: ctl_o.op = OP_SLTU;
        default: ;
      endcase
    end else begin
      ctl_o.use_imm = 1'b1;
      unique case (opc)
        6'h08: begin ctl_o.op = OP_ADD; ctl_o.chk = 1'b1; ctl_o.imm_sext = 1'b1; end
        6'h09: ctl_o.op = OP_ADD;
        6'h0A: begin ctl_o.op = OP_SLT; ctl_o.imm_sext = 1'b1; end
        6'h0B: ctl_o.op = OP_SLTU;
        6'h0C: ctl_o.op = OP_AND;
        6'h0D: ctl_o.op = OP_OR;
        6'h0E: ctl_o.op = OP_XOR;
        6'h0F: ctl_o.op = OP_LUI;
        default: ctl_o.use_imm = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         chk_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
  // same-sign operands producing an opposite-sign sum
  assign ovf_o = chk_i & (a_i[W-1] == b_eff[W-1]) & (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W  = 64,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  res_o
);
  logic         fill;
  logic [W-1:0] stg [0:SW];

  assign fill   = arith_i & val_i[W-1];
  assign stg[0] = val_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stg[k+1] = !amt_i[k] ? stg[k] :
                      left_i    ? {stg[k][W-1-D:0], {D{1'b0}}} :
                                  {{D{fill}}, stg[k][W-1:D]};
  end

  assign res_o = stg[SW];
endmodule

// File: rtl/alu64.sv
module alu64
  import alu_pkg::*;
#(
  parameter int W     = 64,
  parameter int IMM_W = 16
) (
  input  logic [31:0]  instr_i,
  input  logic [W-1:0] rs_i,
  input  logic [W-1:0] rt_i,
  output logic [W-1:0] result_o,
  output logic         ovf_o
);
  localparam int SW = $clog2(W);

  alu_ctl_t       ctl;
  logic [IMM_W-1:0] imm;
  logic [W-1:0]   imm_ext, opb, sum, sh_res;
  logic [SW-1:0]  sh_amt;
  logic           lt_s, lt_u, ovf_raw;

  alu_decode u_dec (.instr_i(instr_i), .ctl_o(ctl));

  assign imm     = instr_i[IMM_W-1:0];
  assign imm_ext = ctl.imm_sext ? {{(W-IMM_W){imm[IMM_W-1]}}, imm}
                                : {{(W-IMM_W){1'b0}}, imm};
  assign opb     = ctl.use_imm ? imm_ext : rt_i;

  alu_addsub #(.W(W)) u_addsub (
    .a_i(rs_i), .b_i(opb), .sub_i(ctl.op == OP_SUB),
    .chk_i(ctl.chk && (ctl.op == OP_ADD || ctl.op == OP_SUB)),
    .sum_o(sum), .ovf_o(ovf_raw)
  );

  // immediate amount: instr[21] is the high bit, instr[10:6] the rest
  assign sh_amt = ctl.var_sh ? rs_i[SW-1:0] : {instr_i[21], instr_i[10:6]};

  alu_shift #(.W(W), .SW(SW)) u_shift (
    .val_i(rt_i), .amt_i(sh_amt), .left_i(ctl.op == OP_SLL),
    .arith_i(ctl.op == OP_SRA), .res_o(sh_res)
  );

  assign lt_s = $signed(rs_i) < $signed(opb);
  assign lt_u = rs_i < opb;

  always_comb begin
    unique case (ctl.op)
      OP_ADD, OP_SUB:         result_o = sum;
      OP_AND:                 result_o = rs_i & opb;
      OP_OR:                  result_o = rs_i | opb;
      OP_XOR:                 result_o = rs_i ^ opb;
      OP_NOR:                 result_o = ~(rs_i | opb);
      OP_SLL, OP_SRL, OP_SRA: result_o = sh_res;
      OP_SLT:                 result_o = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:                result_o = {{(W-1){1'b0}}, lt_u};
      OP_LUI:                 result_o = {{(W-2*IMM_W){1'b0}}, imm, {IMM_W{1'b0}}};
      default:                result_o = '0;
    endcase
  end
  assign ovf_o = ovf_raw;

  always_comb begin
    // R2
    ovf_scope_chk: assert (!ovf_o || (ctl.chk && (ctl.op == OP_ADD || ctl.op == OP_SUB)));
    // R2
    if (ovf_o && ctl.op == OP_ADD) ovf_sign_chk: assert (result_o[W-1] != rs_i[W-1]);
    // R7
    if (ctl.op == OP_SLT || ctl.op == OP_SLTU) slt_bool_chk: assert (result_o[W-1:1] == '0);
    // R9
    if (ctl.op == OP_LUI) lui_low_chk: assert (result_o[IMM_W-1:0] == '0);
    // R10
    if (ctl.op == OP_NONE) illegal_zero_chk: assert (result_o == '0 && !ovf_o);
    // R4
    if ((ctl.op == OP_SLL || ctl.op == OP_SRL || ctl.op == OP_SRA) && sh_amt == '0)
      shift_zero_chk: assert (result_o == rt_i);
  end
endmodule

// File: tb/alu64_bench.sv
module alu64_bench;
  function automatic logic [31:0] rty(logic [5:0] fn, logic [5:0] sh);
    return {6'h00, 4'h0, sh[5], 10'h000, sh[4:0], fn};
  endfunction
  function automatic logic [31:0] ity(logic [5:0] opc, logic [15:0] imm);
    return {opc, 10'h000, imm};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
    logic        ovf;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] LA   = 64'h00FF_00FF_F0F0_1234;
  localparam logic [63:0] LB   = 64'h0F0F_0F0F_FFFF_0000;
  localparam int NV = 31;

  localparam vec_t VECS [NV] = '{
    '{rty(6'h20, 6'd0), 64'd5, 64'd7, 64'd12, 1'b0, 8'd1},                 // R1
    '{rty(6'h20, 6'd0), MAXP, 64'd1, MINN, 1'b1, 8'd2},                    // R2
    '{rty(6'h21, 6'd0), MAXP, 64'd1, MINN, 1'b0, 8'd2},                    // R2
    '{rty(6'h22, 6'd0), 64'd3, 64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 8'd1}, // R1
    '{rty(6'h22, 6'd0), MINN, 64'd1, MAXP, 1'b1, 8'd2},                    // R2
    '{rty(6'h23, 6'd0), MINN, 64'd1, MAXP, 1'b0, 8'd2},                    // R2
    '{rty(6'h22, 6'd0), 64'd0, MINN, MINN, 1'b1, 8'd2},                    // R2
    '{rty(6'h24, 6'd0), LA, LB, 64'h000F_000F_F0F0_0000, 1'b0, 8'd3},      // R3
    '{rty(6'h25, 6'd0), LA, LB, 64'h0FFF_0FFF_FFFF_1234, 1'b0, 8'd3},      // R3
    '{rty(6'h26, 6'd0), LA, LB, 64'h0FF0_0FF0_0F0F_1234, 1'b0, 8'd3},      // R3
    '{rty(6'h27, 6'd0), LA, LB, 64'hF000_F000_0000_EDCB, 1'b0, 8'd3},      // R3
    '{rty(6'h00, 6'd36), 64'd0, 64'hAB, 64'h0000_0AB0_0000_0000, 1'b0, 8'd4}, // R4
    '{rty(6'h02, 6'd63), 64'd0, MINN, 64'd1, 1'b0, 8'd4},                  // R4
    '{rty(6'h03, 6'd4), 64'd0, MINN, 64'hF800_0000_0000_0000, 1'b0, 8'd6}, // R6
    '{rty(6'h03, 6'd32), 64'd0, 64'h7000_0000_0000_0000, 64'h7000_0000, 1'b0, 8'd6}, // R6
    '{rty(6'h02, 6'd4), 64'd0, MINN, 64'h0800_0000_0000_0000, 1'b0, 8'd6}, // R6
    '{rty(6'h04, 6'd0), 64'hFFFF_FFFF_FFFF_FF41, 64'd3, 64'd6, 1'b0, 8'd5}, // R5
    '{rty(6'h06, 6'd0), 64'h3C, 64'hF000_0000_0000_0000, 64'hF, 1'b0, 8'd5}, // R5
    '{rty(6'h07, 6'd0), 64'h7F, MINN, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 8'd5}, // R5
    '{rty(6'h2A, 6'd0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd1, 1'b0, 8'd7}, // R7
    '{rty(6'h2B, 6'd0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 1'b0, 8'd7}, // R7
    '{rty(6'h2A, 6'd0), 64'd5, 64'd5, 64'd0, 1'b0, 8'd7},                  // R7
    '{ity(6'h08, 16'hFFFF), 64'd10, 64'd0, 64'd9, 1'b0, 8'd8},             // R8
    '{ity(6'h08, 16'h0001), MAXP, 64'd0, MINN, 1'b1, 8'd2},                // R2
    '{ity(6'h09, 16'hFFFF), 64'd10, 64'd0, 64'h1_0009, 1'b0, 8'd8},        // R8
    '{ity(6'h0C, 16'h8001), 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'h8001, 1'b0, 8'd8}, // R8
    '{ity(6'h0E, 16'h00FF), 64'hFFFF, 64'd0, 64'hFF00, 1'b0, 8'd8},        // R8
    '{ity(6'h0A, 16'hFFFF), 64'd0, 64'd0, 64'd0, 1'b0, 8'd8},              // R8
    '{ity(6'h0B, 16'hFFFF), 64'h10, 64'd0, 64'd1, 1'b0, 8'd8},             // R8
    '{ity(6'h0F, 16'h8765), 64'hDEAD, 64'd0, 64'h8765_0000, 1'b0, 8'd9},   // R9
    '{ity(6'h02, 16'h1234), 64'd7, 64'd9, 64'd0, 1'b0, 8'd10}              // R10
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr;
  logic [63:0] rs, rt, res;
  logic        ovf;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  alu64 u_alu64 (.instr_i(instr), .rs_i(rs), .rt_i(rt), .result_o(res), .ovf_o(ovf));

  task automatic apply(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] exp, input logic eo, input string tag);
    @(negedge clk);
    instr = ins; rs = a; rt = b;
    @(posedge clk);
    #1;
    n_vec++;
    if (res !== exp || ovf !== eo) begin
      n_bad++;
      $display("FAIL %s: instr=%h result=%h ovf=%b expected result=%h ovf=%b",
               tag, ins, res, ovf, exp, eo);
    end
  endtask

  initial begin
    instr = '0; rs = '0; rt = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R4: all-zero word is a shift by zero; rt passes through
    apply(32'h0, 64'hFFFF, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 1'b0, "R4");
    for (int i = 0; i < NV; i++)
      apply(VECS[i].ins, VECS[i].a, VECS[i].b, VECS[i].exp, VECS[i].ovf,
            $sformatf("R%0d", VECS[i].req));
    // R5: upper rs bits ignored (rs=0x...C0 has low six bits zero)
    apply(rty(6'h04, 6'd0), 64'hFFFF_FFFF_FFFF_FFC0, 64'h55, 64'h55, 1'b0, "R5");
    // R4: split field high bit alone selects 32
    apply(rty(6'h00, 6'd32), 64'd0, 64'h1, 64'h1_0000_0000, 1'b0, "R4");
    // R10: jump-register funct is not an ALU op
    apply(rty(6'h08, 6'd0), 64'd3, 64'd4, 64'd0, 1'b0, "R10");
    // R9: ori zero-extends, lui ignores rs and leaves high half zero
    apply(ity(6'h0D, 16'h8000), 64'd0, 64'd0, 64'h8000, 1'b0, "R8");
    apply(ity(6'h0F, 16'hFFFF), 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'hFFFF_0000, 1'b0, "R9");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule